// File: doc/BRIEF.md
# Paged Mailbox Data Window

This block lets a CPU reach the data bytes of fifteen message mailboxes through two registers: a page register and a single data port. The page register names one mailbox and one byte position inside that mailbox's eight-byte buffer. Every read or write on the data port goes to the byte that the page register names.

A CPU usually writes the page register once for a mailbox. It then streams bytes through the data port, and the byte index steps forward after each access. Setting the hold bit in the page register turns that stepping off, so that the same byte can be polled or rewritten repeatedly. The index wraps inside the selected mailbox and never moves on to the next mailbox. A page value that names mailbox 15 has no storage behind it: writes through it are dropped and reads through it return zero.

Top module: `mbox_page_access`

## Requirements
- R1: After reset the page register reads 0x00, which means mailbox 0, auto-increment on and byte index 0. The mailbox data storage is not reset.
- R2: A page write (`page_wr`) loads all three page fields at once from `page_wdata`. The fields are: mailbox number in bits 7:4, hold bit in bit 3, byte index in bits 2:0. `page_rdata` shows the new value one clock edge later.
- R3: A data-port write (`data_wr`) stores `data_wdata` into the byte of the selected mailbox given by the current index, at the clock edge of the strobe.
- R4: `data_rdata` is combinational from the selected byte. It is valid in the same cycle as the read strobe and reflects the page register as it stands before the edge.
- R5: When the hold bit is 0, every cycle with `data_rd`, `data_wr` or both asserted advances the index by exactly one at that clock edge.
- R6: The index counts modulo 8. It wraps from 7 to 0, and the mailbox number and hold bit are unchanged by any data access.
- R7: When the hold bit is 1, data accesses leave the whole page register unchanged.
- R8: A page whose mailbox number is 15 is invalid. Writes through it change no stored byte, and `data_rdata` reads 0x00. Its index still follows R5/R7.
- R9: When a page write and a data access occur in the same cycle, the data access uses the old page. The page register takes the written value with no increment applied.
- R10: A write to one mailbox leaves the bytes of every other mailbox unchanged, including the bytes at the same index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the page register |
| page_wr | input | 1 | Page register write strobe |
| page_wdata | input | 8 | New page value {mailbox[3:0], hold, index[2:0]} |
| page_rdata | output | 8 | Current page register value |
| data_rd | input | 1 | Data-port read strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_wdata | input | 8 | Byte to store at the selected location |
| data_rdata | output | 8 | Byte at the selected location (0x00 for an invalid page) |

## Verification
The block produces results on two timings. Read data is due in the same cycle as the strobe, because it depends only on the current page. Page changes, index steps and stored bytes are due one clock edge after the strobe. The bench drives each strobe at a falling edge. It captures `data_rdata` shortly after that, before the rising edge, and reads `page_rdata` or read-back data at the next falling edge. Each sample therefore falls on the cycle in which its result is due, and the stimulus for the following cycle is not yet applied.

// File: rtl/mbpg_pkg.sv
package mbpg_pkg;

    localparam int MB_W  = 4;
    localparam int IDX_W = 3;
    localparam int DW    = 8;

    // Page register layout: mailbox in the upper nibble, hold bit, byte index
    typedef struct packed {
        logic [MB_W-1:0]  mbox;
        logic             hold;
        logic [IDX_W-1:0] idx;
    } page_t;

endpackage

// File: rtl/mbpg_page_reg.sv
module mbpg_page_reg
    import mbpg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  page_t load_val,
    input  logic  access,
    output page_t page
);

    typedef struct packed {
        page_t pg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.pg = load_val;
        end else if (access && !st_q.pg.hold) begin
            st_d.pg.idx = st_q.pg.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page = st_q.pg;

endmodule

// File: rtl/mbpg_decode.sv
module mbpg_decode
    import mbpg_pkg::*;
#(
    parameter int NUM_MBOX = 15
) (
    input  logic [MB_W-1:0]     mbox,
    output logic                valid,
    output logic [NUM_MBOX-1:0] sel
);

    assign valid = (int'(mbox) < NUM_MBOX);

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_sel
        assign sel[g] = (mbox == MB_W'(g));
    end

endmodule

// File: rtl/mbpg_store.sv
module mbpg_store #(
    parameter int NUM_MBOX  = 15,
    parameter int BUF_BYTES = 8,
    parameter int DW        = 8
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [NUM_MBOX-1:0]          sel,
    input  logic [$clog2(BUF_BYTES)-1:0] idx,
    input  logic [DW-1:0]                wdata,
    output logic [DW-1:0]                rdata
);

    logic [DW-1:0] rd_byte [NUM_MBOX];

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_mbox
        logic [DW-1:0] buf_q [BUF_BYTES];

        always_ff @(posedge clk) begin
            if (we && sel[g]) begin
                buf_q[idx] <= wdata;
            end
        end

        assign rd_byte[g] = buf_q[idx];
    end

    // One-hot OR mux: an empty select yields zero
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_MBOX; k++) begin
            if (sel[k]) begin
                rdata = rdata | rd_byte[k];
            end
        end
    end

endmodule

// File: rtl/mbox_page_access.sv
module mbox_page_access
    import mbpg_pkg::*;
#(
    parameter int NUM_MBOX  = 15,
    parameter int BUF_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          page_wr,
    input  logic [DW-1:0] page_wdata,
    output logic [DW-1:0] page_rdata,
    input  logic          data_rd,
    input  logic          data_wr,
    input  logic [DW-1:0] data_wdata,
    output logic [DW-1:0] data_rdata
);

    localparam int BIDX_W = $clog2(BUF_BYTES);

    page_t               page;
    logic                mb_valid;
    logic [NUM_MBOX-1:0] mb_sel;
    logic                access;
    logic                wr_en;

    assign access = data_rd | data_wr;
    assign wr_en  = data_wr & mb_valid;

    mbpg_page_reg i_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (page_wr),
        .load_val (page_t'(page_wdata)),
        .access   (access),
        .page     (page)
    );

    mbpg_decode #(.NUM_MBOX(NUM_MBOX)) i_dec (
        .mbox  (page.mbox),
        .valid (mb_valid),
        .sel   (mb_sel)
    );

    mbpg_store #(
        .NUM_MBOX  (NUM_MBOX),
        .BUF_BYTES (BUF_BYTES),
        .DW        (DW)
    ) i_store (
        .clk   (clk),
        .we    (wr_en),
        .sel   (mb_sel),
        .idx   (page.idx[BIDX_W-1:0]),
        .wdata (data_wdata),
        .rdata (data_rdata)
    );

    assign page_rdata = page;

endmodule

// File: rtl/mbpg_checker.sv
module mbpg_checker #(
    parameter int NUM_MBOX = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       page_wr,
    input logic [7:0] page_wdata,
    input logic [7:0] page_rdata,
    input logic       data_rd,
    input logic       data_wr,
    input logic [7:0] data_rdata
);

    logic was_rst;
    logic acc;

    assign acc = data_rd | data_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) was_rst <= 1'b1;
        else        was_rst <= 1'b0;
    end

    p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst == 1'b1) |-> (page_rdata == 8'h00));

    p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr |=> (page_rdata == $past(page_wdata)));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_wr && acc && !page_rdata[3]) |=>
            (page_rdata[2:0] == 3'($past(page_rdata[2:0]) + 3'd1)));

    p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !page_wr |=> (page_rdata[7:3] == $past(page_rdata[7:3])));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_wr && page_rdata[3]) |=> $stable(page_rdata));

    p_invalid_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(page_rdata[7:4]) >= NUM_MBOX) |-> (data_rdata == 8'h00));

    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (page_wr && acc) |=> (page_rdata == $past(page_wdata)));

endmodule

bind mbox_page_access mbpg_checker #(.NUM_MBOX(NUM_MBOX)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_wr    (page_wr),
    .page_wdata (page_wdata),
    .page_rdata (page_rdata),
    .data_rd    (data_rd),
    .data_wr    (data_wr),
    .data_rdata (data_rdata)
);

// File: tb/test_mbox_page_access.sv
module test_mbox_page_access;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       page_wr = 1'b0;
    logic [7:0] page_wdata = '0;
    logic [7:0] page_rdata;
    logic       data_rd = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic [7:0] data_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [15][8];

    always #2 clk = ~clk;

    mbox_page_access i_mbox_page_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_wr    (page_wr),
        .page_wdata (page_wdata),
        .page_rdata (page_rdata),
        .data_rd    (data_rd),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .data_rdata (data_rdata)
    );

    function automatic logic [7:0] pg(int m, bit h, int i);
        return {4'(m), h, 3'(i)};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic set_page(logic [7:0] v);
        @(negedge clk);
        page_wr = 1'b1; page_wdata = v;
        @(negedge clk);
        page_wr = 1'b0;
    endtask

    task automatic do_write(logic [7:0] v);
        @(negedge clk);
        data_wr = 1'b1; data_wdata = v;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        data_rd = 1'b1;
        #1 v = data_rdata;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic verify_all(string req);
        logic [7:0] v;
        for (int m = 0; m < 15; m++) begin
            set_page(pg(m, 1'b0, 0));
            for (int i = 0; i < 8; i++) begin
                do_read(v);
                chk(req, v, model[m][i]);
            end
        end
    endtask

    task automatic t_reset_r1();
        chk("R1 reset page", page_rdata, 8'h00);
    endtask

    task automatic t_fill_r3();
        logic [7:0] v;
        for (int m = 0; m < 15; m++) begin
            set_page(pg(m, 1'b0, 0));
            chk("R2 page load", page_rdata, pg(m, 1'b0, 0));
            for (int i = 0; i < 8; i++) begin
                v = 8'(m * 16 + i) ^ 8'hA5;
                do_write(v);
                model[m][i] = v;
            end
            chk("R6 wrap after 8 writes", page_rdata, pg(m, 1'b0, 0));
        end
        for (int m = 0; m < 15; m++) begin
            set_page(pg(m, 1'b0, 0));
            for (int i = 0; i < 8; i++) begin
                do_read(v);
                chk("R3 R4 read back", v, model[m][i]);
                chk("R5 R6 index step", page_rdata, pg(m, 1'b0, (i + 1) % 8));
            end
        end
    endtask

    task automatic t_hold_r7();
        logic [7:0] v;
        set_page(pg(3, 1'b1, 5));
        for (int k = 0; k < 3; k++) begin
            do_read(v);
            chk("R7 held read data", v, model[3][5]);
            chk("R7 held page", page_rdata, pg(3, 1'b1, 5));
        end
        do_write(8'h11);
        do_write(8'h77);
        model[3][5] = 8'h77;
        chk("R7 held page after writes", page_rdata, pg(3, 1'b1, 5));
        do_read(v);
        chk("R7 R3 rewritten byte", v, 8'h77);
    endtask

    task automatic t_rdwr_r5();
        logic [7:0] v;
        set_page(pg(6, 1'b0, 2));
        @(negedge clk);
        data_rd = 1'b1; data_wr = 1'b1; data_wdata = 8'h5A;
        #1 v = data_rdata;
        chk("R4 read before write edge", v, model[6][2]);
        @(negedge clk);
        data_rd = 1'b0; data_wr = 1'b0;
        model[6][2] = 8'h5A;
        chk("R5 single step for rd+wr", page_rdata, pg(6, 1'b0, 3));
        set_page(pg(6, 1'b1, 2));
        do_read(v);
        chk("R3 combined write stored", v, 8'h5A);
    endtask

    task automatic t_invalid_r8();
        logic [7:0] v;
        set_page(pg(15, 1'b0, 2));
        do_read(v);
        chk("R8 invalid read zero", v, 8'h00);
        chk("R8 index steps on invalid page", page_rdata, pg(15, 1'b0, 3));
        do_write(8'hFF);
        chk("R8 index steps on invalid write", page_rdata, pg(15, 1'b0, 4));
        verify_all("R8 storage untouched");
    endtask

    task automatic t_isolate_r10();
        set_page(pg(4, 1'b1, 6));
        do_write(8'hC3);
        model[4][6] = 8'hC3;
        verify_all("R10 other mailboxes intact");
    endtask

    task automatic t_collide_r9();
        logic [7:0] v;
        set_page(pg(2, 1'b0, 1));
        @(negedge clk);
        page_wr = 1'b1; page_wdata = pg(7, 1'b1, 4);
        data_wr = 1'b1; data_wdata = 8'h3C;
        @(negedge clk);
        page_wr = 1'b0; data_wr = 1'b0;
        model[2][1] = 8'h3C;
        chk("R9 page wins, no step", page_rdata, pg(7, 1'b1, 4));
        #1 v = data_rdata;
        chk("R9 R4 new page read", v, model[7][4]);
        verify_all("R9 write used old page");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_fill_r3();
        t_hold_r7();
        t_rdwr_r5();
        t_invalid_r8();
        t_isolate_r10();
        t_collide_r9();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule